// File: doc/BRIEF.md
# Two-Channel Cycle-Stealing DMA Controller

This block moves data between two locations on a bus it shares with a processor, one unit per request. It has two independent channels. Each one is started either by a software request strobe or by one peripheral interrupt line that a per-channel select field picks. A started transfer asks for the bus, waits for the grant, reads one unit into an internal holding latch and writes it out in the next cycle. It then drops the bus for at least one cycle, so the processor is only ever held off for a few cycles at a time.

A channel keeps a fixed source base, a fixed destination base, and a forward pointer that walks the address on the side chosen to advance. A transfer counter counts the remaining units and reloads when it runs out. At that point the forward pointer returns to its base and the channel pulses a done output. In one-shot mode it also disables itself. The interrupt lines are only observed and are never acknowledged. No mask gates them, so a line that is selected and pulsed always counts as a request. Requests that arrive while one is already pending on the same channel are merged into it.

Top module: `dmac2ch`

## Requirements
- R1: Each accepted request produces exactly one read cycle followed in the very next cycle by one write cycle. In wide mode (`unit16`=1) the 16-bit value read at the read address appears on `bus_wdata` at the write address, with `bus_wide`=1.
- R2: In byte mode (`unit16`=0) only bits 7:0 of the read data are moved. Bits 15:8 of `bus_wdata` are 0 and `bus_wide` is 0 during both cycles.
- R3: A channel's `trig_sel` value 0 means software requests only. A value k from 1 to NIRQ adds interrupt line `irq_req[k-1]` as a request source. A pulse on any other interrupt line causes no transfer.
- R4: A request arriving while the channel's enable is 0 is discarded. No bus activity follows, not even after the channel is enabled later.
- R5: Extra requests on a channel while its request is still pending (bus not yet granted) merge into a single transfer.
- R6: When several channels are pending, the lowest-numbered channel is served first.
- R7: `bus_req` is high from before the read cycle to the end of the write cycle. `bus_rd`/`bus_wr` are only ever high while `bus_gnt` is high, and never both together. With `bus_gnt` held low, the block waits with `bus_req`=1 and no strobe.
- R8: `cfg_load` sets the bases, the forward pointer and the counter. With `adv_src`=1 the read address is the forward pointer and the write address stays at the destination base. With `adv_src`=0 the roles swap. The forward pointer steps by 2 after a wide transfer and by 1 after a byte transfer.
- R9: After N transfers (N = loaded count) the channel pulses `done` for one cycle, the counter reloads to N and the forward pointer returns to its base. In repeat mode (`one_shot`=0) the channel stays enabled.
- R10: In one-shot mode the terminal transfer clears the channel's enable (`chan_en`=0), and later requests cause no transfer.
- R11: After reset `bus_req`, `bus_rd`, `bus_wr`, `done` and `chan_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req | input | NCH | Software request strobe per channel |
| irq_req | input | NIRQ | Peripheral interrupt request pulses |
| trig_sel | input | NCH x SEL_W | Per-channel trigger select (0 = software only, k = line k-1) |
| en_wr | input | NCH | Enable write strobe per channel |
| en_wdata | input | NCH | Enable value written on `en_wr` |
| one_shot | input | NCH | 1 = disable at terminal count, 0 = repeat |
| unit16 | input | NCH | 1 = wide unit, 0 = byte unit |
| adv_src | input | NCH | 1 = source side advances, 0 = destination side advances |
| cfg_load | input | NCH | Load bases, forward pointer and counter |
| load_src | input | PTR_W | Source base to load |
| load_dst | input | PTR_W | Destination base to load |
| load_cnt | input | CNT_W | Transfer count / reload value |
| chan_en | output | NCH | Current enable state per channel |
| done | output | NCH | One-cycle terminal-count pulse per channel |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | PTR_W | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wide | output | 1 | Unit width of current cycle |
| bus_wdata | output | DATA_W | Write data from the latch |
| bus_rdata | input | DATA_W | Read data (valid in the read cycle) |

## Verification
The bench holds the grant off while requests pile up. A design that did not merge them would then issue several transfers where one is expected. It fires both channels in the same cycle, and a wrong priority shows up as write addresses in the wrong order. It drives the terminal count in repeat mode and in one-shot mode, where an off-by-one counter, a forward pointer that fails to return to its base or an enable left set shows up as wrong addresses or extra writes. It also pulses an unselected interrupt line and requests a disabled channel, where a leaky trigger path or a pending flag not gated by enable would produce a stray write.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_REQ  = 2'd1,
      XS_RD   = 2'd2,
      XS_WR   = 2'd3
   } xfer_state_t;

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan #(
   parameter int PTR_W     = 20,
   parameter int CNT_W     = 16,
   parameter int WIDE_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_in,
   input  logic             en_wr,
   input  logic             en_wdata,
   input  logic             one_shot,
   input  logic             unit16,
   input  logic             adv_src,
   input  logic             load,
   input  logic [PTR_W-1:0] load_src,
   input  logic [PTR_W-1:0] load_dst,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             start,
   input  logic             commit,
   output logic             pend,
   output logic             en,
   output logic [PTR_W-1:0] rd_addr,
   output logic [PTR_W-1:0] wr_addr,
   output logic             done
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [PTR_W-1:0] src_q, dst_q, fwd_q;
   logic [CNT_W-1:0] cnt_q, rld_q;
   logic             en_q, pend_q, done_q;
   logic             term;
   logic [PTR_W-1:0] step, base_fwd;

   assign term     = (cnt_q == CNT_ONE);
   assign step     = unit16 ? PTR_W'(WIDE_STEP) : PTR_W'(1);
   assign base_fwd = adv_src ? src_q : dst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         fwd_q <= '0;
         cnt_q <= '0;
         rld_q <= '0;
      end else if (load) begin
         src_q <= load_src;
         dst_q <= load_dst;
         fwd_q <= adv_src ? load_src : load_dst;
         cnt_q <= load_cnt;
         rld_q <= load_cnt;
      end else if (commit) begin
         fwd_q <= term ? base_fwd : fwd_q + step;
         cnt_q <= term ? rld_q : cnt_q - CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (en_wr)
            en_q <= en_wdata;
         else if (commit && term && one_shot)
            en_q <= 1'b0;
         if (load)
            pend_q <= 1'b0;
         else
            pend_q <= en_q & ((pend_q & ~start) | req_in);
         done_q <= commit & term;
      end
   end

   assign pend    = pend_q;
   assign en      = en_q;
   assign done    = done_q;
   assign rd_addr = adv_src ? fwd_q : src_q;
   assign wr_addr = adv_src ? dst_q : fwd_q;

   // R10: terminal transfer in one-shot mode leaves the channel disabled
   a_r10_oneshot_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && term && one_shot && !en_wr) |=> !en_q);

   // R9: the terminal pulse lasts one cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R5: a started transfer consumes the merged pending request
   a_r5_pend_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !req_in) |=> !pend_q);

endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
   parameter int NCH = 2,
   localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [NCH-1:0]   req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
   import dmac_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int PTR_W  = 20,
   parameter int DATA_W = 16,
   localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NCH-1:0]              req_v,
   input  logic [IDX_W-1:0]            pick_idx,
   input  logic                        pick_any,
   input  logic                        gnt,
   input  logic [NCH-1:0][PTR_W-1:0]   rd_addr_v,
   input  logic [NCH-1:0][PTR_W-1:0]   wr_addr_v,
   input  logic [NCH-1:0]              wide_v,
   input  logic [DATA_W-1:0]           rdata,
   output logic [NCH-1:0]              start,
   output logic [NCH-1:0]              commit,
   output logic                        bus_req,
   output logic [PTR_W-1:0]            bus_addr,
   output logic                        bus_rd,
   output logic                        bus_wr,
   output logic                        bus_wide,
   output logic [DATA_W-1:0]           bus_wdata
);

   xfer_state_t        state_q;
   logic [IDX_W-1:0]   cur_q;
   logic [DATA_W-1:0]  latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         cur_q   <= '0;
         latch_q <= '0;
      end else begin
         unique case (state_q)
            XS_IDLE: if (pick_any) begin
               cur_q   <= pick_idx;
               state_q <= XS_REQ;
            end
            XS_REQ:  if (gnt) state_q <= XS_RD;
            XS_RD: begin
               latch_q <= wide_v[cur_q] ? rdata
                                        : {{(DATA_W-8){1'b0}}, rdata[7:0]};
               state_q <= XS_WR;
            end
            XS_WR:   state_q <= XS_IDLE;
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         start[i]  = (state_q == XS_REQ) && gnt && (cur_q == IDX_W'(i));
         commit[i] = (state_q == XS_WR) && (cur_q == IDX_W'(i));
      end
   end

   assign bus_req   = (state_q != XS_IDLE);
   assign bus_rd    = (state_q == XS_RD);
   assign bus_wr    = (state_q == XS_WR);
   assign bus_addr  = bus_rd ? rd_addr_v[cur_q] : (bus_wr ? wr_addr_v[cur_q] : '0);
   assign bus_wide  = (bus_rd || bus_wr) && wide_v[cur_q];
   assign bus_wdata = bus_wr ? latch_q : '0;

   // R7: strobes only under grant, never together, write right after read
   a_r7_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> (gnt && bus_req));
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_rd, bus_wr}));
   a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> $past(bus_rd));

   // R6: channel 0 wins whenever it is pending at selection time
   a_r6_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XS_IDLE && req_v[0]) |=> (cur_q == '0));

endmodule

// File: rtl/dmac2ch.sv
module dmac2ch #(
   parameter int NCH    = 2,
   parameter int NIRQ   = 4,
   parameter int PTR_W  = 20,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   localparam int SEL_W = $clog2(NIRQ + 1),
   localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NCH-1:0]              sw_req,
   input  logic [NIRQ-1:0]             irq_req,
   input  logic [NCH-1:0][SEL_W-1:0]   trig_sel,
   input  logic [NCH-1:0]              en_wr,
   input  logic [NCH-1:0]              en_wdata,
   input  logic [NCH-1:0]              one_shot,
   input  logic [NCH-1:0]              unit16,
   input  logic [NCH-1:0]              adv_src,
   input  logic [NCH-1:0]              cfg_load,
   input  logic [PTR_W-1:0]            load_src,
   input  logic [PTR_W-1:0]            load_dst,
   input  logic [CNT_W-1:0]            load_cnt,
   output logic [NCH-1:0]              chan_en,
   output logic [NCH-1:0]              done,
   output logic                        bus_req,
   input  logic                        bus_gnt,
   output logic [PTR_W-1:0]            bus_addr,
   output logic                        bus_rd,
   output logic                        bus_wr,
   output logic                        bus_wide,
   output logic [DATA_W-1:0]           bus_wdata,
   input  logic [DATA_W-1:0]           bus_rdata
);

   localparam int WIDE_STEP = DATA_W / 8;

   if (NCH < 1)                          begin : g_bad_nch   $error("NCH must be at least 1"); end
   if (NIRQ < 1)                         begin : g_bad_nirq  $error("NIRQ must be at least 1"); end
   if (PTR_W < 4)                        begin : g_bad_ptr   $error("PTR_W too small"); end
   if (CNT_W < 2)                        begin : g_bad_cnt   $error("CNT_W too small"); end
   if (DATA_W < 16 || DATA_W % 8 != 0)   begin : g_bad_data  $error("DATA_W must be a byte multiple of at least 16"); end

   logic [NCH-1:0]             pend, req_in, start, commit, ready;
   logic [NCH-1:0][PTR_W-1:0]  rd_addr_v, wr_addr_v;
   logic [IDX_W-1:0]           pick_idx;
   logic                       pick_any;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic irq_hit;

      always_comb begin
         irq_hit = 1'b0;
         for (int k = 0; k < NIRQ; k++) begin
            if (trig_sel[c] == SEL_W'(k + 1)) irq_hit = irq_req[k];
         end
      end

      assign req_in[c] = sw_req[c] | irq_hit;
      assign ready[c]  = pend[c] & chan_en[c];

      dmac_chan #(
         .PTR_W     (PTR_W),
         .CNT_W     (CNT_W),
         .WIDE_STEP (WIDE_STEP)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_in   (req_in[c]),
         .en_wr    (en_wr[c]),
         .en_wdata (en_wdata[c]),
         .one_shot (one_shot[c]),
         .unit16   (unit16[c]),
         .adv_src  (adv_src[c]),
         .load     (cfg_load[c]),
         .load_src (load_src),
         .load_dst (load_dst),
         .load_cnt (load_cnt),
         .start    (start[c]),
         .commit   (commit[c]),
         .pend     (pend[c]),
         .en       (chan_en[c]),
         .rd_addr  (rd_addr_v[c]),
         .wr_addr  (wr_addr_v[c]),
         .done     (done[c])
      );
   end

   dmac_arb #(.NCH(NCH)) u_arb (
      .req (ready),
      .idx (pick_idx),
      .any (pick_any)
   );

   dmac_xfer #(
      .NCH    (NCH),
      .PTR_W  (PTR_W),
      .DATA_W (DATA_W)
   ) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_v     (ready),
      .pick_idx  (pick_idx),
      .pick_any  (pick_any),
      .gnt       (bus_gnt),
      .rd_addr_v (rd_addr_v),
      .wr_addr_v (wr_addr_v),
      .wide_v    (unit16),
      .rdata     (bus_rdata),
      .start     (start),
      .commit    (commit),
      .bus_req   (bus_req),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wide  (bus_wide),
      .bus_wdata (bus_wdata)
   );

   // R4: a disabled channel never raises a transfer start
   a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (|(start & ~chan_en & ~$past(chan_en))) |-> 1'b0);

endmodule

// File: tb/tb_dmac2ch.sv
module tb_dmac2ch;

   localparam int NCH = 2, NIRQ = 4, PTR_W = 20, CNT_W = 16, DATA_W = 16;
   localparam int SEL_W = $clog2(NIRQ + 1);

   typedef struct {
      logic [PTR_W-1:0]  addr;
      logic [DATA_W-1:0] data;
      logic              wide;
   } exp_t;

   logic                      clk = 1'b0, rst_n = 1'b0;
   logic [NCH-1:0]            sw_req = '0, en_wr = '0, en_wdata = '0;
   logic [NCH-1:0]            one_shot = '0, unit16 = '0, adv_src = '0, cfg_load = '0;
   logic [NIRQ-1:0]           irq_req = '0;
   logic [NCH-1:0][SEL_W-1:0] trig_sel = '0;
   logic [PTR_W-1:0]          load_src = '0, load_dst = '0;
   logic [CNT_W-1:0]          load_cnt = '0;
   logic [NCH-1:0]            chan_en, done;
   logic                      bus_req, bus_gnt, bus_rd, bus_wr, bus_wide;
   logic [PTR_W-1:0]          bus_addr;
   logic [DATA_W-1:0]         bus_wdata, bus_rdata;
   logic                      hold_gnt = 1'b0;

   logic [7:0] mem [0:4095];

   always #2 clk = ~clk;

   assign bus_gnt   = bus_req & ~hold_gnt;
   assign bus_rdata = {mem[12'(bus_addr + 1)], mem[bus_addr[11:0]]};

   dmac2ch #(.NCH(NCH), .NIRQ(NIRQ), .PTR_W(PTR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .irq_req(irq_req), .trig_sel(trig_sel),
      .en_wr(en_wr), .en_wdata(en_wdata), .one_shot(one_shot), .unit16(unit16),
      .adv_src(adv_src), .cfg_load(cfg_load), .load_src(load_src), .load_dst(load_dst),
      .load_cnt(load_cnt), .chan_en(chan_en), .done(done), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   int    n_chk = 0, n_fail = 0, wr_cnt = 0, strobe_bad = 0;
   int    got_done [NCH];
   int    exp_done [NCH];
   exp_t  q [$];
   string cur_tag = "R1";

   // reference channel model
   logic [PTR_W-1:0] m_src [NCH], m_dst [NCH], m_fwd [NCH];
   logic [CNT_W-1:0] m_cnt [NCH], m_rld [NCH];
   logic             m_w [NCH], m_adv [NCH];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: pops expected writes and checks them
   always @(negedge clk) begin
      if (rst_n) begin
         if ((bus_rd || bus_wr) && !bus_gnt) strobe_bad++;
         for (int i = 0; i < NCH; i++) if (done[i]) got_done[i]++;
         if (bus_wr) begin
            wr_cnt++;
            if (q.size() == 0) begin
               chk(1'b0, cur_tag, "unexpected write at", 32'(bus_addr), 32'hFFFFFFFF);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(bus_addr == e.addr, cur_tag, "write address", 32'(bus_addr), 32'(e.addr));
               chk(bus_wdata == e.data, cur_tag, "write data", 32'(bus_wdata), 32'(e.data));
               chk(bus_wide == e.wide, cur_tag, "unit width", 32'(bus_wide), 32'(e.wide));
            end
            mem[bus_addr[11:0]] = bus_wdata[7:0];
            if (bus_wide) mem[12'(bus_addr + 1)] = bus_wdata[15:8];
         end
      end
   end

   task automatic configure(input int ch, input logic [PTR_W-1:0] s, input logic [PTR_W-1:0] d,
                            input logic [CNT_W-1:0] n, input bit os, input bit w, input bit adv);
      @(negedge clk);
      one_shot[ch] = os; unit16[ch] = w; adv_src[ch] = adv;
      load_src = s; load_dst = d; load_cnt = n; cfg_load[ch] = 1'b1;
      @(negedge clk);
      cfg_load[ch] = 1'b0;
      m_src[ch] = s; m_dst[ch] = d; m_fwd[ch] = adv ? s : d;
      m_cnt[ch] = n; m_rld[ch] = n; m_w[ch] = w; m_adv[ch] = adv;
   endtask

   task automatic set_en(input int ch, input bit v);
      @(negedge clk);
      en_wr[ch] = 1'b1; en_wdata[ch] = v;
      @(negedge clk);
      en_wr[ch] = 1'b0;
   endtask

   // driver side of the scoreboard: predict one transfer of channel ch
   task automatic expect_xfer(input int ch);
      exp_t e;
      logic [PTR_W-1:0] ra;
      ra     = m_adv[ch] ? m_fwd[ch] : m_src[ch];
      e.addr = m_adv[ch] ? m_dst[ch] : m_fwd[ch];
      e.wide = m_w[ch];
      e.data = m_w[ch] ? {mem[12'(ra + 1)], mem[ra[11:0]]} : {8'h00, mem[ra[11:0]]};
      q.push_back(e);
      if (m_cnt[ch] == 1) begin
         m_fwd[ch] = m_adv[ch] ? m_src[ch] : m_dst[ch];
         m_cnt[ch] = m_rld[ch];
         exp_done[ch]++;
      end else begin
         m_fwd[ch] = m_fwd[ch] + (m_w[ch] ? 2 : 1);
         m_cnt[ch] = m_cnt[ch] - 1;
      end
   endtask

   task automatic pulse_sw(input logic [NCH-1:0] m);
      @(negedge clk); sw_req = m;
      @(negedge clk); sw_req = '0;
   endtask

   task automatic pulse_irq(input int line);
      @(negedge clk); irq_req[line] = 1'b1;
      @(negedge clk); irq_req = '0;
   endtask

   task automatic settle();
      repeat (16) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
      report();
   end

   initial begin
      int base_wr;
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
      for (int i = 0; i < NCH; i++) begin got_done[i] = 0; exp_done[i] = 0; end
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(bus_req == 1'b0 && bus_rd == 1'b0 && bus_wr == 1'b0, "R11", "bus idle in reset", 32'(bus_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(chan_en == '0, "R11", "enables after reset", 32'(chan_en), 32'd0);
      chk(done == '0 && bus_req == 1'b0, "R11", "done/bus_req after reset", 32'(done), 32'd0);

      // R1/R8/R9: wide, source advancing, repeat mode, count 3
      cur_tag = "R8";
      configure(0, 20'h00100, 20'h00800, 16'd3, 1'b0, 1'b1, 1'b1);
      set_en(0, 1'b1);
      for (int k = 0; k < 3; k++) begin expect_xfer(0); pulse_sw(2'b01); settle(); end
      chk(got_done[0] == 1, "R9", "done pulses after 3 transfers", 32'(got_done[0]), 32'd1);
      chk(chan_en[0] == 1'b1, "R9", "repeat mode stays enabled", 32'(chan_en[0]), 32'd1);
      cur_tag = "R9";
      expect_xfer(0); pulse_sw(2'b01); settle();

      // R3/R2/R10: channel 1 from interrupt line 1, byte unit, dest advancing, one-shot
      cur_tag = "R3";
      trig_sel[1] = SEL_W'(2);
      configure(1, 20'h00200, 20'h00900, 16'd2, 1'b1, 1'b0, 1'b0);
      set_en(1, 1'b1);
      base_wr = wr_cnt;
      pulse_irq(0); pulse_irq(2); settle();
      chk(wr_cnt == base_wr, "R3", "unselected lines give no write", 32'(wr_cnt - base_wr), 32'd0);
      cur_tag = "R2";
      for (int k = 0; k < 2; k++) begin expect_xfer(1); pulse_irq(1); settle(); end
      chk(got_done[1] == 1, "R10", "one-shot terminal pulse", 32'(got_done[1]), 32'd1);
      chk(chan_en[1] == 1'b0, "R10", "one-shot clears enable", 32'(chan_en[1]), 32'd0);
      base_wr = wr_cnt;
      pulse_irq(1); pulse_sw(2'b10); settle();
      chk(wr_cnt == base_wr, "R10", "no transfer after one-shot end", 32'(wr_cnt - base_wr), 32'd0);

      // R6: both channels requested in the same cycle
      cur_tag = "R6";
      configure(0, 20'h00400, 20'h00B00, 16'd10, 1'b0, 1'b1, 1'b1);
      configure(1, 20'h00300, 20'h00A00, 16'd10, 1'b0, 1'b1, 1'b1);
      set_en(1, 1'b1);
      expect_xfer(0); expect_xfer(1);
      pulse_sw(2'b11); settle(); settle();

      // R5/R7: requests merge while the grant is held off
      cur_tag = "R5";
      hold_gnt = 1'b1;
      base_wr = wr_cnt;
      expect_xfer(0);
      pulse_sw(2'b01); pulse_sw(2'b01); pulse_sw(2'b01);
      repeat (4) @(negedge clk);
      chk(bus_req == 1'b1 && bus_rd == 1'b0 && bus_wr == 1'b0, "R7", "waiting for grant",
          32'({bus_req, bus_rd, bus_wr}), 32'b100);
      hold_gnt = 1'b0;
      settle();
      chk(wr_cnt - base_wr == 1, "R5", "merged requests give one write", 32'(wr_cnt - base_wr), 32'd1);

      // R4: request to a disabled channel is dropped
      cur_tag = "R4";
      set_en(0, 1'b0);
      base_wr = wr_cnt;
      pulse_sw(2'b01); settle();
      set_en(0, 1'b1); settle();
      chk(wr_cnt == base_wr, "R4", "disabled request dropped", 32'(wr_cnt - base_wr), 32'd0);
      expect_xfer(0); pulse_sw(2'b01); settle();

      chk(q.size() == 0, "R1", "all predicted transfers seen", 32'(q.size()), 32'd0);
      chk(strobe_bad == 0, "R7", "strobes outside grant", 32'(strobe_bad), 32'd0);
      chk(got_done[0] == exp_done[0] && got_done[1] == exp_done[1], "R9", "done pulse totals",
          32'(got_done[0] * 16 + got_done[1]), 32'(exp_done[0] * 16 + exp_done[1]));
      report();
   end

endmodule